// File: doc/BRIEF.md
# Program Load and Reset Controller

This block stands between a small set of external control pins and an on-chip program store of 256 instructions. Each instruction is three bytes wide: an opcode slot, a first-operand slot and a second-operand slot. When the surrounding processor signals, through a one-cycle strobe, that the current instruction has finished, the controller looks at a load-request pin and a two-bit slot selector. A plain load request writes one byte into one slot of one instruction. The instruction index comes from the upper byte of a 16-bit I/O bus, and the data byte comes from the lower byte. While it does this, the controller drives a 4-bit status code.

The same pins also carry two levels of reset. A load request with the selector at its all-ones value is a soft reset. It clears the program counter and the status, and does nothing else in that cycle. If that pattern is seen at five boundary checks in a row, the fifth one becomes a full reset. The full reset refills the whole store with 0xFF in one cycle and tells the rest of the processor to clear its registers, its stack and its cycle counter. Whenever the controller has read the pins with a request present, it asks the pin logic to drop the request and selector lines back to zero. A read port lets the executing core, or a test, fetch any stored byte.

Top module: `prog_load_ctrl`

## Requirements
- R1: After reset, status is 0, every stored byte reads 0xFF, and pin_clear, pc_clear and full_reset are low.
- R2: A check with load_req=1 and slot_sel 00, 01 or 10 writes io_bus[7:0] into the opcode, first-operand or second-operand slot (rd_slot 0, 1 or 2) of the instruction whose index is io_bus[15:8].
- R3: An accepted load shows status 5 in the cycle after the check, then status 2 for two cycles, and then status 4.
- R4: Pins are sampled only in a cycle where instr_done=1 and no load is in progress. Strobes that arrive during the three load cycles have no effect on status, memory, pc_clear or pin_clear.
- R5: pin_clear is high for exactly the cycle after a check that found load_req=1, and low after any other check.
- R6: A check with load_req=1 and slot_sel=11 makes status 0 and raises pc_clear for one cycle, and it leaves the stored bytes unchanged.
- R7: The fifth consecutive soft-reset check also raises full_reset for one cycle, together with pc_clear. In that cycle every stored byte reads 0xFF.
- R8: Any check that does not find the soft-reset pattern restarts the count of consecutive soft-reset checks. A full reset also restarts it.
- R9: A check with load_req=0 sets status to 4 and raises neither pc_clear nor full_reset.
- R10: rd_slot=11 always reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_done | input | 1 | Strobe: current instruction finished, check the pins |
| load_req | input | 1 | Load-request pin |
| slot_sel | input | 2 | Slot selector: 00 opcode, 01 operand 1, 10 operand 2, 11 reset pattern |
| io_bus | input | 16 | Upper byte instruction index, lower byte data |
| rd_index | input | 8 | Read port instruction index |
| rd_slot | input | 2 | Read port slot (0..2; 3 reads 0xFF) |
| status | output | 4 | Status code: 0 ready, 2 running, 4 instruction done, 5 load started |
| rd_data | output | 8 | Stored byte at rd_index / rd_slot |
| pin_clear | output | 1 | Request to clear load and selector pins |
| pc_clear | output | 1 | One-cycle program counter clear |
| full_reset | output | 1 | One-cycle full reset to registers, stack and cycle counter |

## Verification
The soft reset and the full reset fall in the same cycle. On the fifth consecutive reset-pattern check, pc_clear and full_reset must both pulse, the status must return to 0 and the store must be refilled, all at once. The bench provokes this after first filling several slots, and after a run of four soft resets that a load interrupts. It then judges the store by reading back locations written earlier, and it confirms that a further four soft resets do not trigger a second full reset. A second overlap is also exercised: strobes that carry the reset pattern are held high during a load, and they must leave both the status sequence and the pulses untouched.

// File: rtl/plc_pkg.sv
package plc_pkg;
  localparam logic [3:0] ST_READY   = 4'd0;
  localparam logic [3:0] ST_RUN     = 4'd2;
  localparam logic [3:0] ST_DONE    = 4'd4;
  localparam logic [3:0] ST_LOADING = 4'd5;

  localparam logic [1:0] SLOT_RST = 2'b11;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LD1  = 2'd1,
    SQ_LD2  = 2'd2,
    SQ_LD3  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/plc_rst_sync.sv
module plc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/plc_rst_count.sv
module plc_rst_count #(
  parameter int CHECKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic check,
  input  logic is_rst,
  output logic full_hit
);
  localparam int CNT_W = $clog2(CHECKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHECKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    full_hit = check && is_rst && (cnt_q == LAST);
    cnt_en   = check;
    if (!is_rst || full_hit) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/plc_seq.sv
module plc_seq
  import plc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instr_done,
  input  logic       load_req,
  input  logic [1:0] slot_sel,
  input  logic       full_hit,
  output logic       check,
  output logic       is_rst,
  output logic       wr_en,
  output logic [3:0] status,
  output logic       pin_clear,
  output logic       pc_clear,
  output logic       full_reset
);
  seq_state_e state_q, state_d;
  logic [3:0] status_q, status_d;
  logic       pin_d, pcc_d, full_d;

  always_comb begin
    check    = instr_done && (state_q == SQ_IDLE);
    is_rst   = load_req && (slot_sel == SLOT_RST);
    wr_en    = check && load_req && !is_rst;
    state_d  = state_q;
    status_d = status_q;
    pin_d    = 1'b0;
    pcc_d    = 1'b0;
    full_d   = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (check) begin
          pin_d = load_req;
          if (is_rst) begin
            status_d = ST_READY;
            pcc_d    = 1'b1;
            full_d   = full_hit;
          end else if (load_req) begin
            state_d  = SQ_LD1;
            status_d = ST_LOADING;
          end else begin
            status_d = ST_DONE;
          end
        end
      end
      SQ_LD1: begin
        state_d  = SQ_LD2;
        status_d = ST_RUN;
      end
      SQ_LD2: begin
        state_d  = SQ_LD3;
        status_d = ST_RUN;
      end
      SQ_LD3: begin
        state_d  = SQ_IDLE;
        status_d = ST_DONE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      status_q   <= ST_READY;
      pin_clear  <= 1'b0;
      pc_clear   <= 1'b0;
      full_reset <= 1'b0;
    end else begin
      state_q    <= state_d;
      status_q   <= status_d;
      pin_clear  <= pin_d;
      pc_clear   <= pcc_d;
      full_reset <= full_d;
    end
  end

  assign status = status_q;
endmodule

// File: rtl/plc_mem.sv
module plc_mem #(
  parameter int DEPTH  = 256,
  parameter int SLOTS  = 3,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(DEPTH)-1:0]  wr_index,
  input  logic [1:0]                wr_slot,
  input  logic [BYTE_W-1:0]         wr_data,
  input  logic                      fill_en,
  input  logic [$clog2(DEPTH)-1:0]  rd_index,
  input  logic [1:0]                rd_slot,
  output logic [BYTE_W-1:0]         rd_data
);
  logic [SLOTS-1:0][BYTE_W-1:0] slot_rd;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [BYTE_W-1:0] cells [DEPTH];
    logic              slot_we;

    assign slot_we = wr_en && (wr_slot == 2'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int e = 0; e < DEPTH; e++) cells[e] <= '1;
      end else if (fill_en) begin
        for (int e = 0; e < DEPTH; e++) cells[e] <= '1;
      end else if (slot_we) begin
        cells[wr_index] <= wr_data;
      end
    end

    assign slot_rd[s] = cells[rd_index];
  end

  always_comb begin
    rd_data = '1;
    for (int s = 0; s < SLOTS; s++) begin
      if (rd_slot == 2'(s)) rd_data = slot_rd[s];
    end
  end
endmodule

// File: rtl/prog_load_ctrl.sv
module prog_load_ctrl #(
  parameter int DEPTH        = 256,
  parameter int BYTE_W       = 8,
  parameter int RESET_CHECKS = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     instr_done,
  input  logic                     load_req,
  input  logic [1:0]               slot_sel,
  input  logic [2*BYTE_W-1:0]      io_bus,
  input  logic [$clog2(DEPTH)-1:0] rd_index,
  input  logic [1:0]               rd_slot,
  output logic [3:0]               status,
  output logic [BYTE_W-1:0]        rd_data,
  output logic                     pin_clear,
  output logic                     pc_clear,
  output logic                     full_reset
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int SLOTS = 3;

  logic rst_n_s;
  logic check, is_rst, wr_en, full_hit;

  plc_rst_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  plc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .instr_done(instr_done),
    .load_req  (load_req),
    .slot_sel  (slot_sel),
    .full_hit  (full_hit),
    .check     (check),
    .is_rst    (is_rst),
    .wr_en     (wr_en),
    .status    (status),
    .pin_clear (pin_clear),
    .pc_clear  (pc_clear),
    .full_reset(full_reset)
  );

  plc_rst_count #(.CHECKS(RESET_CHECKS)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .check   (check),
    .is_rst  (is_rst),
    .full_hit(full_hit)
  );

  plc_mem #(.DEPTH(DEPTH), .SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_index(io_bus[BYTE_W +: IDX_W]),
    .wr_slot (slot_sel),
    .wr_data (io_bus[BYTE_W-1:0]),
    .fill_en (full_hit),
    .rd_index(rd_index),
    .rd_slot (rd_slot),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/prog_load_ctrl_chk.sv
module prog_load_ctrl_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_done,
  input logic              load_req,
  input logic [1:0]        slot_sel,
  input logic [3:0]        status,
  input logic [BYTE_W-1:0] rd_data,
  input logic              pin_clear,
  input logic              pc_clear,
  input logic              full_reset
);
  AST_LOAD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'd5) |-> $past(instr_done && load_req && slot_sel != 2'b11)); // R3
  AST_LOAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'd5) |=> (status == 4'd2)); // R3
  AST_BUSY_NO_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'd2) |-> !pc_clear && !full_reset); // R4
  AST_SOFT_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    pc_clear |-> pin_clear && (status == 4'd0)); // R5
  AST_FULL_WITH_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    full_reset |-> pc_clear); // R7
  AST_FULL_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    full_reset |-> (rd_data == '1)); // R7
endmodule

bind prog_load_ctrl prog_load_ctrl_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .instr_done(instr_done),
  .load_req  (load_req),
  .slot_sel  (slot_sel),
  .status    (status),
  .rd_data   (rd_data),
  .pin_clear (pin_clear),
  .pc_clear  (pc_clear),
  .full_reset(full_reset)
);

// File: tb/prog_load_ctrl_bench.sv
`timescale 1ns/1ps
module prog_load_ctrl_bench;
  localparam int RESET_CHECKS = 5;
  localparam int K_STATUS = 0, K_PC = 1, K_FULL = 2, K_PIN = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_done = 1'b0;
  logic        load_req = 1'b0;
  logic [1:0]  slot_sel = 2'b00;
  logic [15:0] io_bus = 16'h0000;
  logic [7:0]  rd_index = 8'h00;
  logic [1:0]  rd_slot = 2'b00;
  logic [3:0]  status;
  logic [7:0]  rd_data;
  logic        pin_clear, pc_clear, full_reset;

  prog_load_ctrl u_prog_load_ctrl (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .load_req(load_req),
    .slot_sel(slot_sel), .io_bus(io_bus), .rd_index(rd_index), .rd_slot(rd_slot),
    .status(status), .rd_data(rd_data), .pin_clear(pin_clear),
    .pc_clear(pc_clear), .full_reset(full_reset)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    cyc;
    int    kind;
    int    exp;
    string tag;
  } item_t;

  item_t      sb_q[$];
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  int         rcnt = 0;
  logic [7:0] mdl [256][3];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int at, input int kind, input int exp, input string tag);
    item_t it;
    it.cyc = at; it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  function automatic int observe(input int kind);
    case (kind)
      K_STATUS: return int'(status);
      K_PC:     return int'(pc_clear);
      K_FULL:   return int'(full_reset);
      default:  return int'(pin_clear);
    endcase
  endfunction

  // monitor: compares every expected item whose cycle has come
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].cyc <= cyc) begin
        checks++;
        if (sb_q[i].cyc < cyc || observe(sb_q[i].kind) != sb_q[i].exp) begin
          fails++;
          $display("FAIL %s kind=%0d cycle=%0d actual=%0d expected=%0d",
                   sb_q[i].tag, sb_q[i].kind, sb_q[i].cyc, observe(sb_q[i].kind), sb_q[i].exp);
        end
        sb_q.delete(i);
      end
    end
  end

  task automatic check_val(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_mem(input logic [7:0] idx, input logic [1:0] slot, input string tag);
    @(negedge clk);
    rd_index = idx; rd_slot = slot;
    #1;
    check_val(int'(rd_data), (slot == 2'b11) ? 8'hFF : int'(mdl[idx][slot]), tag);
  endtask

  // driver: one boundary check, with expectations pushed to the scoreboard
  task automatic issue(input bit ld, input logic [1:0] sel, input logic [7:0] idx,
                       input logic [7:0] dat, input bit poke, input string tag);
    int c;
    bit rstp, full;
    @(negedge clk);
    c = cyc;
    instr_done = 1'b1; load_req = ld; slot_sel = sel; io_bus = {idx, dat};
    rstp = ld && (sel == 2'b11);
    if (rstp) begin
      rcnt++;
      full = (rcnt == RESET_CHECKS);
      if (full) begin
        rcnt = 0;
        for (int e = 0; e < 256; e++) for (int s = 0; s < 3; s++) mdl[e][s] = 8'hFF;
      end
      push(c + 1, K_STATUS, 0, tag);
      push(c + 1, K_PC, 1, tag);
      push(c + 1, K_FULL, int'(full), tag);
      push(c + 1, K_PIN, 1, "R5");
    end else if (ld) begin
      rcnt = 0;
      mdl[idx][sel] = dat;
      push(c + 1, K_STATUS, 5, "R3");
      push(c + 2, K_STATUS, 2, "R3");
      push(c + 3, K_STATUS, 2, "R3");
      push(c + 4, K_STATUS, 4, "R3");
      push(c + 1, K_PIN, 1, "R5");
      push(c + 1, K_PC, 0, tag);
      push(c + 1, K_FULL, 0, tag);
      if (poke) begin
        push(c + 2, K_PC, 0, "R4");
        push(c + 3, K_PC, 0, "R4");
        push(c + 2, K_PIN, 0, "R4");
        push(c + 3, K_PIN, 0, "R4");
      end
    end else begin
      rcnt = 0;
      push(c + 1, K_STATUS, 4, "R9");
      push(c + 1, K_PC, 0, "R9");
      push(c + 1, K_FULL, 0, "R9");
      push(c + 1, K_PIN, 0, "R5");
    end
    @(negedge clk);
    if (ld && !rstp) begin
      if (poke) begin
        load_req = 1'b1; slot_sel = 2'b11; instr_done = 1'b1;
        repeat (2) @(negedge clk);
        instr_done = 1'b0; load_req = 1'b0; slot_sel = 2'b00;
        @(negedge clk);
      end else begin
        instr_done = 1'b0; load_req = 1'b0; slot_sel = 2'b00;
        repeat (3) @(negedge clk);
      end
    end else begin
      instr_done = 1'b0; load_req = 1'b0; slot_sel = 2'b00;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    summary();
  end

  initial begin
    for (int e = 0; e < 256; e++) for (int s = 0; s < 3; s++) mdl[e][s] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    check_val(int'(status), 0, "R1 status");
    check_val(int'(pc_clear), 0, "R1 pc_clear");
    check_val(int'(full_reset), 0, "R1 full_reset");
    check_val(int'(pin_clear), 0, "R1 pin_clear");
    check_mem(8'h00, 2'd0, "R1");
    check_mem(8'hFF, 2'd2, "R1");
    check_mem(8'h80, 2'd1, "R1");

    issue(1'b0, 2'b00, 8'h00, 8'h00, 1'b0, "R9");       // R9 no request
    issue(1'b0, 2'b10, 8'h12, 8'h34, 1'b0, "R9");
    check_mem(8'h12, 2'd2, "R9 unchanged");

    issue(1'b1, 2'b00, 8'h12, 8'hA5, 1'b0, "R2");       // R2 opcode slot
    issue(1'b1, 2'b01, 8'h12, 8'h34, 1'b0, "R2");
    issue(1'b1, 2'b10, 8'h12, 8'h56, 1'b0, "R2");
    issue(1'b1, 2'b10, 8'hFF, 8'h00, 1'b0, "R2");
    issue(1'b1, 2'b00, 8'h00, 8'h9F, 1'b0, "R2");
    check_mem(8'h12, 2'd0, "R2");
    check_mem(8'h12, 2'd1, "R2");
    check_mem(8'h12, 2'd2, "R2");
    check_mem(8'hFF, 2'd2, "R2");
    check_mem(8'h00, 2'd0, "R2");
    check_mem(8'h13, 2'd0, "R2 neighbour");
    check_mem(8'h12, 2'd3, "R10");                     // R10 slot 3 reads FF

    issue(1'b1, 2'b01, 8'h40, 8'h77, 1'b1, "R4");       // R4 strobes during load
    check_mem(8'h40, 2'd1, "R4");

    for (int k = 0; k < 4; k++) issue(1'b1, 2'b11, 8'h00, 8'h00, 1'b0, "R6");
    issue(1'b1, 2'b01, 8'h41, 8'h11, 1'b0, "R8");       // R8 break the run
    for (int k = 0; k < 4; k++) issue(1'b1, 2'b11, 8'h00, 8'h00, 1'b0, "R8");
    issue(1'b0, 2'b00, 8'h00, 8'h00, 1'b0, "R8");
    for (int k = 0; k < 4; k++) issue(1'b1, 2'b11, 8'h00, 8'h00, 1'b0, "R8");
    check_mem(8'h12, 2'd0, "R6 memory kept");
    check_mem(8'h41, 2'd1, "R6 memory kept");

    issue(1'b1, 2'b11, 8'h00, 8'h00, 1'b0, "R7");       // R7 fifth in a row
    check_mem(8'h12, 2'd0, "R7 refill");
    check_mem(8'h12, 2'd1, "R7 refill");
    check_mem(8'h40, 2'd1, "R7 refill");
    check_mem(8'hFF, 2'd2, "R7 refill");

    for (int k = 0; k < 4; k++) issue(1'b1, 2'b11, 8'h00, 8'h00, 1'b0, "R8 restart");
    issue(1'b1, 2'b00, 8'h05, 8'hC3, 1'b0, "R2");
    check_mem(8'h05, 2'd0, "R2");

    repeat (8) @(negedge clk);
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard all-requirements actual=%0d expected=0", sb_q.size());
    end
    summary();
  end
endmodule